// File: doc/BRIEF.md
# JTAG Debug Command Controller

This block is the debug command register and action sequencer behind a JTAG TAP controller. While the TAP sits in the IR shift state, it takes an 8-bit command from TDI one bit per TCK, least significant bit first. It sends the previous register contents out on TDO in the same order. On the IR update strobe the shifted value becomes the active command, and the block then serves as the instruction register.

The active command holds a read/write flag, a go (step) flag, an exit flag and a 5-bit register-select code. None of its requests acts at IR update. The register-select strobe, the release pulse to the CPU and the end of the debug session all wait until a following DR scan passes through update-DR. This applies even when the command has no data register at all.

A sticky session flag rises when the CPU enters debug state. It stays up while the CPU steps in and out of debug state one instruction at a time. It falls only on a go+exit command aimed at "no register" or the CPU scan register.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: `tapReset` high at a TCK edge sets the active command to rs=0x1F, go=0, ex=0, rw=0. It also clears all strobes, `cpuRelease` and `sessionActive`, so a following update-DR produces no strobe.
- R2: `captureIr` at a TCK edge loads the shift register with 0x01. The 8 bits then seen on `tdo` during shift-IR are 0x01, least significant bit first.
- R3: Each TCK edge with `shiftIr` high moves the shift register one place toward bit 0, and `tdi` enters at bit 7. `tdo` shows bit 0, so a second 8-bit scan returns the first scan's value.
- R4: The active command changes only at an edge with `updateIr` high. No strobe and no release appear at IR update, and a shift without IR update leaves the active command unchanged.
- R5: The command layout is bit 7 = rw, bit 6 = go, bit 5 = ex, bits 4:0 = rs. At an edge with `updateDr` high, rs=0x00 gives `selCpuScan`, rs=0x11 gives `selControl` and rs=0x12 gives `selStatus`, each for exactly one TCK cycle. Any other rs gives no strobe.
- R6: At an edge with `updateDr` high and go=1, `cpuRelease` is high for exactly one TCK cycle after that edge. Without update-DR there is no release.
- R7: A rising `cpuInDebug` sets `sessionActive` one cycle later. The flag stays set through go-only steps and while the CPU leaves and re-enters debug state.
- R8: `sessionActive` is cleared at update-DR only when go=1, ex=1 and rs is 0x1F or 0x00. go+ex with any other rs performs the access and the release but keeps the flag.
- R9: If a rising `cpuInDebug` and a clearing update-DR fall on the same edge, the rising edge wins and `sessionActive` stays set.
- R10: `readReq` equals the rw bit of the active command (1 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tapReset | input | 1 | Synchronous test-logic-reset indication, active high |
| tdi | input | 1 | Serial data in |
| captureIr | input | 1 | TAP is in capture-IR |
| shiftIr | input | 1 | TAP is in shift-IR |
| updateIr | input | 1 | TAP is in update-IR |
| updateDr | input | 1 | TAP is in update-DR |
| cpuInDebug | input | 1 | CPU reports it is in debug state |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| readReq | output | 1 | rw bit of the active command |
| selCpuScan | output | 1 | One-cycle select of the CPU scan register |
| selControl | output | 1 | One-cycle select of the control register |
| selStatus | output | 1 | One-cycle select of the status register |
| cpuRelease | output | 1 | One-cycle step/exit release to the CPU |
| sessionActive | output | 1 | Sticky debug-session flag |

## Verification
The session flag's set path and clear path can meet on one edge. This happens when the CPU's debug indication rises in the same TCK cycle that update-DR executes a go+exit command to "no register". The bench provokes it by loading that command, then raising `cpuInDebug` and `updateDr` together before a single edge. It judges the outcome by `sessionActive` reading 1 after that edge, with the release pulse still present.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int CMD_W = 8;
  localparam int RS_W  = 5;
  localparam int NSEL  = 3;

  localparam logic [RS_W-1:0] RS_CPU  = 5'h00;
  localparam logic [RS_W-1:0] RS_CTRL = 5'h11;
  localparam logic [RS_W-1:0] RS_STAT = 5'h12;
  localparam logic [RS_W-1:0] RS_NONE = 5'h1F;

  // select index 0 = CPU scan, 1 = control, 2 = status
  localparam logic [NSEL*RS_W-1:0] SEL_CODES = {RS_STAT, RS_CTRL, RS_CPU};

  localparam logic [CMD_W-1:0] CAPTURE_PAT = 8'h01;

  typedef struct packed {
    logic            rw;
    logic            go;
    logic            ex;
    logic [RS_W-1:0] rs;
  } cmd_t;

  localparam cmd_t CMD_IDLE = '{rw: 1'b0, go: 1'b0, ex: 1'b0, rs: RS_NONE};

  typedef struct packed {
    logic clear;
    logic capture;
    logic shift;
    logic latch;
  } dpCtl_t;
endpackage

// File: rtl/dbg_cmd_dp.sv
module dbg_cmd_dp
  import dbg_cmd_pkg::*;
(
  input  logic   tck,
  input  dpCtl_t ctl,
  input  logic   tdi,
  output logic   tdo,
  output cmd_t   cmd
);
  logic [CMD_W-1:0] shiftReg;

  always_ff @(posedge tck) begin
    if (ctl.clear) begin
      shiftReg <= CAPTURE_PAT;
      cmd      <= CMD_IDLE;
    end else begin
      if (ctl.capture)
        shiftReg <= CAPTURE_PAT;
      else if (ctl.shift)
        shiftReg <= {tdi, shiftReg[CMD_W-1:1]};
      if (ctl.latch)
        cmd <= cmd_t'(shiftReg);
    end
  end

  assign tdo = shiftReg[0];

  p_capture_pattern_r2: assert property (@(posedge tck) disable iff (ctl.clear)
    ctl.capture |=> shiftReg == CAPTURE_PAT);

  p_shift_entry_r3: assert property (@(posedge tck) disable iff (ctl.clear)
    (ctl.shift && !ctl.capture) |=> shiftReg[CMD_W-1] == $past(tdi));

  p_cmd_hold_r4: assert property (@(posedge tck) disable iff (ctl.clear)
    !ctl.latch |=> $stable(cmd));
endmodule

// File: rtl/dbg_cmd_ctl.sv
module dbg_cmd_ctl
  import dbg_cmd_pkg::*;
(
  input  logic            tck,
  input  logic            tapReset,
  input  logic            captureIr,
  input  logic            shiftIr,
  input  logic            updateIr,
  input  logic            updateDr,
  input  logic            cpuInDebug,
  input  cmd_t            cmd,
  output dpCtl_t          dpCtl,
  output logic [NSEL-1:0] selPulse,
  output logic            releasePulse,
  output logic            sessionActive,
  output logic            readReq
);
  logic [NSEL-1:0] rsHit;
  logic            prevDebug;
  logic            enterDebug;
  logic            exitHit;

  assign dpCtl = '{clear: tapReset, capture: captureIr, shift: shiftIr, latch: updateIr};

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign rsHit[g] = (cmd.rs == SEL_CODES[g*RS_W +: RS_W]);
  end

  assign enterDebug = cpuInDebug && !prevDebug;
  assign exitHit    = updateDr && cmd.go && cmd.ex &&
                      (cmd.rs == RS_NONE || cmd.rs == RS_CPU);
  assign readReq    = cmd.rw;

  always_ff @(posedge tck) begin
    if (tapReset) begin
      selPulse      <= '0;
      releasePulse  <= 1'b0;
      sessionActive <= 1'b0;
      prevDebug     <= 1'b0;
    end else begin
      selPulse      <= updateDr ? rsHit : '0;
      releasePulse  <= updateDr && cmd.go;
      prevDebug     <= cpuInDebug;
      sessionActive <= enterDebug || (sessionActive && !exitHit);
    end
  end

  p_sel_onehot_r5: assert property (@(posedge tck) disable iff (tapReset)
    $onehot0(selPulse));

  p_action_gated_r4: assert property (@(posedge tck) disable iff (tapReset)
    ((|selPulse) || releasePulse) |-> $past(updateDr));

  p_release_go_r6: assert property (@(posedge tck) disable iff (tapReset)
    releasePulse |-> $past(cmd.go));

  p_session_entry_r7: assert property (@(posedge tck) disable iff (tapReset)
    $rose(cpuInDebug) |=> sessionActive);

  p_session_clear_r8: assert property (@(posedge tck) disable iff (tapReset)
    ($fell(sessionActive) && !$past(tapReset)) |-> $past(updateDr && cmd.go && cmd.ex));
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic tck,
  input  logic tapReset,
  input  logic tdi,
  input  logic captureIr,
  input  logic shiftIr,
  input  logic updateIr,
  input  logic updateDr,
  input  logic cpuInDebug,
  output logic tdo,
  output logic readReq,
  output logic selCpuScan,
  output logic selControl,
  output logic selStatus,
  output logic cpuRelease,
  output logic sessionActive
);
  dpCtl_t          dpCtl;
  cmd_t            cmd;
  logic [NSEL-1:0] selPulse;

  dbg_cmd_dp u_dp (
    .tck (tck),
    .ctl (dpCtl),
    .tdi (tdi),
    .tdo (tdo),
    .cmd (cmd)
  );

  dbg_cmd_ctl u_ctl (
    .tck           (tck),
    .tapReset      (tapReset),
    .captureIr     (captureIr),
    .shiftIr       (shiftIr),
    .updateIr      (updateIr),
    .updateDr      (updateDr),
    .cpuInDebug    (cpuInDebug),
    .cmd           (cmd),
    .dpCtl         (dpCtl),
    .selPulse      (selPulse),
    .releasePulse  (cpuRelease),
    .sessionActive (sessionActive),
    .readReq       (readReq)
  );

  assign selCpuScan = selPulse[0];
  assign selControl = selPulse[1];
  assign selStatus  = selPulse[2];
endmodule

// File: tb/dbg_cmd_ctrl_tb.sv
module dbg_cmd_ctrl_tb;
  logic tck = 1'b0;
  logic tapReset = 1'b1;
  logic tdi = 1'b0, captureIr = 1'b0, shiftIr = 1'b0, updateIr = 1'b0;
  logic updateDr = 1'b0, cpuInDebug = 1'b0;
  logic tdo, readReq, selCpuScan, selControl, selStatus, cpuRelease, sessionActive;
  int total = 0;
  int bad = 0;

  always #2 tck = ~tck;

  dbg_cmd_ctrl u_dut (
    .tck(tck), .tapReset(tapReset), .tdi(tdi), .captureIr(captureIr),
    .shiftIr(shiftIr), .updateIr(updateIr), .updateDr(updateDr),
    .cpuInDebug(cpuInDebug), .tdo(tdo), .readReq(readReq),
    .selCpuScan(selCpuScan), .selControl(selControl), .selStatus(selStatus),
    .cpuRelease(cpuRelease), .sessionActive(sessionActive)
  );

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {selStatus, selControl, selCpuScan, cpuRelease};
  endfunction

  task automatic irScan(input logic [7:0] val, input bit cap, input bit upd,
                        output logic [7:0] got);
    if (cap) begin
      captureIr = 1'b1; step(); captureIr = 1'b0;
    end
    shiftIr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = val[i];
      got[i] = tdo;
      step();
    end
    shiftIr = 1'b0;
    if (upd) begin
      updateIr = 1'b1; step(); updateIr = 1'b0;
      check(outs() == 0, "R4 no action at IR update", outs(), 0);
    end
  endtask

  // returns {selStatus, selControl, selCpuScan, cpuRelease} seen after update-DR
  task automatic drUpdate(output int seen);
    updateDr = 1'b1; step(); updateDr = 1'b0;
    seen = outs();
    step();
    check(outs() == 0, "R5 R6 one-cycle pulses", outs(), 0);
  endtask

  task automatic load(input logic [7:0] val);
    logic [7:0] g;
    irScan(val, 1'b1, 1'b1, g);
  endtask

  task automatic t_reset();
    int s;
    check(sessionActive == 0 && outs() == 0 && readReq == 0, "R1 reset outputs",
          {sessionActive, readReq, outs()}, 0);
    drUpdate(s);
    check(s == 0, "R1 idle command no strobe", s, 0);
  endtask

  task automatic t_capture();
    logic [7:0] g;
    irScan(8'hC6, 1'b1, 1'b0, g);
    irScan(8'h3C, 1'b1, 1'b1, g);
    check(g == 8'h01, "R2 capture pattern on tdo", g, 8'h01);
  endtask

  task automatic t_shift();
    logic [7:0] g;
    int s;
    irScan(8'hA5, 1'b1, 1'b0, g);
    irScan(8'h3C, 1'b0, 1'b1, g);
    check(g == 8'hA5, "R3 shift-through lsb first", g, 8'hA5);
    drUpdate(s);
    check(s == 0, "R5 unmapped rs no strobe", s, 0);
  endtask

  task automatic t_select();
    int s;
    load(8'h91);
    check(readReq == 1, "R10 read flag", readReq, 1);
    drUpdate(s);
    check(s == 4'b0100, "R5 control select", s, 4'b0100);
    load(8'h12);
    check(readReq == 0, "R10 write flag", readReq, 0);
    drUpdate(s);
    check(s == 4'b1000, "R5 status select", s, 4'b1000);
    load(8'h00);
    drUpdate(s);
    check(s == 4'b0010, "R5 cpu scan select", s, 4'b0010);
  endtask

  task automatic t_latchOnly();
    logic [7:0] g;
    int s;
    load(8'h11);
    irScan(8'h12, 1'b1, 1'b0, g);
    drUpdate(s);
    check(s == 4'b0100, "R4 shift without update keeps command", s, 4'b0100);
  endtask

  task automatic t_step();
    int s;
    cpuInDebug = 1'b1; step();
    check(sessionActive == 1, "R7 session set on entry", sessionActive, 1);
    load(8'h5F);
    drUpdate(s);
    check(s == 4'b0001, "R6 go release", s, 1);
    cpuInDebug = 1'b0; step(); cpuInDebug = 1'b1; step();
    check(sessionActive == 1, "R7 session held across step", sessionActive, 1);
  endtask

  task automatic t_exit();
    int s;
    load(8'h71);
    drUpdate(s);
    check(s == 4'b0101 && sessionActive == 1, "R8 go+ex to control keeps session",
          {sessionActive, s}, 5'h15);
    load(8'h7F);
    drUpdate(s);
    check(s == 4'b0001 && sessionActive == 0, "R8 go+ex none clears session",
          {sessionActive, s}, 5'h01);
    cpuInDebug = 1'b0; step(); cpuInDebug = 1'b1; step();
    check(sessionActive == 1, "R7 new session", sessionActive, 1);
    load(8'h60);
    drUpdate(s);
    check(s == 4'b0011 && sessionActive == 0, "R8 go+ex cpu scan clears session",
          {sessionActive, s}, 5'h03);
  endtask

  task automatic t_collide();
    cpuInDebug = 1'b0; step();
    load(8'h7F);
    cpuInDebug = 1'b1; updateDr = 1'b1; step(); updateDr = 1'b0;
    check(sessionActive == 1 && cpuRelease == 1, "R9 entry wins over exit",
          {sessionActive, cpuRelease}, 3);
    step();
  endtask

  task automatic t_midReset();
    int s;
    load(8'h51);
    tapReset = 1'b1; step(); tapReset = 1'b0;
    check(sessionActive == 0, "R1 reset clears session", sessionActive, 0);
    drUpdate(s);
    check(s == 0, "R1 reset clears command", s, 0);
  endtask

  initial begin
    step(); step();
    tapReset = 1'b0;
    t_reset();
    t_capture();
    t_shift();
    t_select();
    t_latchOnly();
    t_step();
    t_exit();
    t_collide();
    t_midReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule